// File: doc/BRIEF.md
# Bus and Address Fault Controller

This block decides when a faulted bus access turns into an exception, and which vector that exception uses. The bus interface reports faults, and each report carries a kind: instruction prefetch, data read or released (posted) write. The controller also checks every access it sees for an odd address and flags address errors. Each kind of fault waits for its own trigger point. A data read fault fires at once. A prefetch fault waits until the prefetched word is consumed, and a flush discards it. A released-write fault waits for the next instruction boundary or the next operand access.

A taken branch to an odd target raises an address error, and that error records the target both as the fault address and as the return PC. A fault seen while the core is already processing an exception (bus or address error handling, reset handling, or the stack reads of a return from exception) does not trap. It halts the core, and only reset releases the halt. The outputs are a one-cycle exception request with its vector, a sticky halt flag, the latched fault address and the latched return PC. All outputs are registered, so each responds one cycle after the inputs that cause it.

Top module: `bus_fault_ctl`

## Requirements
- R1: A fault report of kind 1 (data read) raises `exc_req` in the next cycle with vector `BE_VEC` (default 2). `flt_addr` takes `fault_addr` and `ret_pc` takes `cur_pc`.
- R2: A fault report of kind 0 (prefetch) is held and raises nothing until `pf_use`, and the request follows one cycle after `pf_use`. If `pf_flush` arrives first, the held prefetch fault is discarded.
- R3: A fault report of kind 2 (released write) is held until `boundary` or `opnd_acc`, whichever comes first, and the request follows one cycle after it.
- R4: An access with `acc_addr[0]`=1 is an address error when it is a fetch (`acc_kind` 0) or has `acc_size` 1 (word) or 2 (long). Size 0 (byte) never causes one. The error uses vector `AE_VEC` (default 3) and follows the timing of its kind (0 prefetch, 1 data read, 2 released write) as in R1 to R3, with the access address as the fault address.
- R5: When `br_vld` and `br_taken` are both high and `br_tgt[0]`=1, an address error is raised in the next cycle, and `flt_addr` and `ret_pc` both equal `br_tgt`. A branch that is not taken raises nothing.
- R6: When a bus error and an address error fire in the same cycle, the bus error vector is reported.
- R7: Any fault report, odd access or odd taken branch seen while `exc_phase` is high sets `halted` in the next cycle and raises no `exc_req`.
- R8: `halted` stays high and `exc_req` stays low until reset.
- R9: Only one deferred fault is held at a time. A second deferred fault that arrives while one is held is dropped. A held fault is cleared when it is taken, when a flush discards it, or on reset.
- R10: After reset, `exc_req` and `halted` are low and no deferred fault is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_vld | input | 1 | A bus fault is reported this cycle |
| fault_kind | input | 2 | 0 prefetch, 1 data read, 2 released write |
| fault_addr | input | AW | Address of the faulted access |
| acc_vld | input | 1 | An access is issued and checked for alignment |
| acc_kind | input | 2 | 0 fetch, 1 data read, 2 released write |
| acc_size | input | 2 | 0 byte, 1 word, 2 long |
| acc_addr | input | AW | Access address |
| br_vld | input | 1 | A branch resolves this cycle |
| br_taken | input | 1 | The branch changes the PC |
| br_tgt | input | AW | Branch target |
| pf_use | input | 1 | The held prefetched word is consumed |
| pf_flush | input | 1 | The prefetch queue is flushed |
| boundary | input | 1 | Instruction boundary |
| opnd_acc | input | 1 | An operand access is attempted |
| exc_phase | input | 1 | The core is in exception processing or the stack reads of a return from exception |
| cur_pc | input | AW | PC of the current instruction |
| exc_req | output | 1 | One-cycle exception request |
| exc_vec | output | VW | Vector of the request |
| halted | output | 1 | Core halted by a double fault |
| flt_addr | output | AW | Latched fault address |
| ret_pc | output | AW | Latched return PC |

## Verification
Directed cases drive each fault kind on its own. They show that a data read fault fires at once, that a held prefetch fault fires only on use and never after a flush, and that a held write fault fires on either a boundary or an operand access. Alignment cases try byte, word and long accesses and fetches at odd addresses, and they separate the byte exemption from the other sizes. Taken, not-taken and even-target branches separate the odd-branch rule from ordinary branch traffic. Collisions (a bus fault and an address error in the same cycle, a second deferred fault while one is held, a fault during exception processing) are then mixed with long runs of sparse random events, with periodic resets, against a cycle model in the bench.

// File: rtl/bus_fault_ctl.sv
module bus_fault_ctl #(
  parameter int AW     = 32,
  parameter int VW     = 8,
  parameter int BE_VEC = 2,
  parameter int AE_VEC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_vld,
  input  logic [1:0]    fault_kind,
  input  logic [AW-1:0] fault_addr,
  input  logic          acc_vld,
  input  logic [1:0]    acc_kind,
  input  logic [1:0]    acc_size,
  input  logic [AW-1:0] acc_addr,
  input  logic          br_vld,
  input  logic          br_taken,
  input  logic [AW-1:0] br_tgt,
  input  logic          pf_use,
  input  logic          pf_flush,
  input  logic          boundary,
  input  logic          opnd_acc,
  input  logic          exc_phase,
  input  logic [AW-1:0] cur_pc,
  output logic          exc_req,
  output logic [VW-1:0] exc_vec,
  output logic          halted,
  output logic [AW-1:0] flt_addr,
  output logic [AW-1:0] ret_pc
);
  localparam logic [1:0] K_PF = 2'd0;
  localparam logic [1:0] K_RD = 2'd1;
  localparam logic [1:0] K_WR = 2'd2;

  logic          pend_v, pend_wr, pend_ae;
  logic [AW-1:0] pend_addr, pend_pc;

  wire acc_odd  = acc_vld && acc_addr[0] && (acc_kind == K_PF || acc_size != 2'd0);
  wire br_odd   = br_vld && br_taken && br_tgt[0];
  wire go_halt  = exc_phase && (fault_vld || acc_odd || br_odd);
  wire pend_hit = pend_v && (pend_wr ? (boundary || opnd_acc) : pf_use);

  wire be_now  = fault_vld && fault_kind == K_RD;
  wire be_late = fault_vld && (fault_kind == K_PF || fault_kind == K_WR);
  wire ae_rd   = acc_odd && acc_kind == K_RD;
  wire ae_late = acc_odd && (acc_kind == K_PF || acc_kind == K_WR);

  logic          fire, fire_ae, take_pend;
  logic [AW-1:0] fire_addr, fire_pc;

  always_comb begin
    fire = 1'b1; fire_ae = 1'b0; take_pend = 1'b0;
    fire_addr = fault_addr; fire_pc = cur_pc;
    if (be_now) begin
    end else if (pend_hit && !pend_ae) begin
      take_pend = 1'b1; fire_addr = pend_addr; fire_pc = pend_pc;
    end else if (ae_rd) begin
      fire_ae = 1'b1; fire_addr = acc_addr;
    end else if (br_odd) begin
      fire_ae = 1'b1; fire_addr = br_tgt; fire_pc = br_tgt;
    end else if (pend_hit) begin
      take_pend = 1'b1; fire_ae = 1'b1; fire_addr = pend_addr; fire_pc = pend_pc;
    end else begin
      fire = 1'b0;
    end
  end

  wire pend_drop = take_pend || (pf_flush && pend_v && !pend_wr);
  wire slot_free = !pend_v || pend_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req <= 1'b0; exc_vec <= '0; halted <= 1'b0;
      flt_addr <= '0; ret_pc <= '0;
      pend_v <= 1'b0; pend_wr <= 1'b0; pend_ae <= 1'b0;
      pend_addr <= '0; pend_pc <= '0;
    end else begin
      exc_req <= 1'b0;
      if (go_halt) halted <= 1'b1;
      if (!halted && !go_halt) begin
        if (fire) begin
          exc_req  <= 1'b1;
          exc_vec  <= fire_ae ? VW'(AE_VEC) : VW'(BE_VEC);
          flt_addr <= fire_addr;
          ret_pc   <= fire_pc;
        end
        if (pend_drop) pend_v <= 1'b0;
        if (slot_free && be_late) begin
          pend_v <= 1'b1; pend_wr <= fault_kind == K_WR; pend_ae <= 1'b0;
          pend_addr <= fault_addr; pend_pc <= cur_pc;
        end else if (slot_free && ae_late) begin
          pend_v <= 1'b1; pend_wr <= acc_kind == K_WR; pend_ae <= 1'b1;
          pend_addr <= acc_addr; pend_pc <= cur_pc;
        end
      end
    end
  end

  p_data_now_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (be_now && !exc_phase && !halted) |=> (exc_req && exc_vec == VW'(BE_VEC)));
  p_odd_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_odd && !exc_phase && !halted) |=> exc_req);
  p_vec_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (exc_vec == VW'(BE_VEC) || exc_vec == VW'(AE_VEC)));
  p_phase_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_phase && fault_vld) |=> (halted && !exc_req));
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !exc_req);
  p_slot_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !pend_drop) |=> (pend_v && $stable(pend_addr)));
endmodule

// File: tb/sim_bus_fault_ctl.sv
`timescale 1ns/1ps
module sim_bus_fault_ctl;
  localparam int AW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fault_vld, acc_vld, br_vld, br_taken, pf_use, pf_flush, boundary, opnd_acc, exc_phase;
  logic [1:0] fault_kind, acc_kind, acc_size;
  logic [AW-1:0] fault_addr, acc_addr, br_tgt, cur_pc;
  logic exc_req, halted;
  logic [7:0] exc_vec;
  logic [AW-1:0] flt_addr, ret_pc;

  always #10 clk = ~clk;

  bus_fault_ctl u0 (.clk, .rst_n, .fault_vld, .fault_kind, .fault_addr, .acc_vld, .acc_kind,
    .acc_size, .acc_addr, .br_vld, .br_taken, .br_tgt, .pf_use, .pf_flush, .boundary,
    .opnd_acc, .exc_phase, .cur_pc, .exc_req, .exc_vec, .halted, .flt_addr, .ret_pc);

  int checks = 0, errors = 0;
  logic m_pv, m_pwr, m_pae, m_halt, e_req;
  logic [7:0] e_vec;
  logic [AW-1:0] m_pa, m_pp, e_addr, e_pc;

  task automatic chk(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    fault_vld = 0; fault_kind = 0; fault_addr = 0; acc_vld = 0; acc_kind = 0; acc_size = 0;
    acc_addr = 0; br_vld = 0; br_taken = 0; br_tgt = 0; pf_use = 0; pf_flush = 0;
    boundary = 0; opnd_acc = 0; exc_phase = 0; cur_pc = 32'h400;
  endtask

  function automatic logic odd_acc();
    return acc_vld && acc_addr[0] && (acc_kind == 0 || acc_size != 0);
  endfunction

  task automatic model();
    logic aodd, bodd, pfire, tookp;
    aodd = odd_acc();
    bodd = br_vld && br_taken && br_tgt[0];
    pfire = m_pv && (m_pwr ? (boundary || opnd_acc) : pf_use);
    e_req = 0; tookp = 0;
    if (m_halt) begin
    end else if (exc_phase && (fault_vld || aodd || bodd)) m_halt = 1;
    else begin
      if (fault_vld && fault_kind == 1) begin
        e_req = 1; e_vec = 2; e_addr = fault_addr; e_pc = cur_pc;
      end else if (pfire && !m_pae) begin
        e_req = 1; e_vec = 2; e_addr = m_pa; e_pc = m_pp; tookp = 1;
      end else if (aodd && acc_kind == 1) begin
        e_req = 1; e_vec = 3; e_addr = acc_addr; e_pc = cur_pc;
      end else if (bodd) begin
        e_req = 1; e_vec = 3; e_addr = br_tgt; e_pc = br_tgt;
      end else if (pfire) begin
        e_req = 1; e_vec = 3; e_addr = m_pa; e_pc = m_pp; tookp = 1;
      end
      if (tookp || (pf_flush && m_pv && !m_pwr)) m_pv = 0;
      if (!m_pv) begin
        if (fault_vld && fault_kind != 1) begin
          m_pv = 1; m_pwr = fault_kind == 2; m_pae = 0; m_pa = fault_addr; m_pp = cur_pc;
        end else if (aodd && acc_kind != 1) begin
          m_pv = 1; m_pwr = acc_kind == 2; m_pae = 1; m_pa = acc_addr; m_pp = cur_pc;
        end
      end
    end
  endtask

  task automatic step(string tag);
    model();
    @(posedge clk); @(negedge clk);
    chk(tag, "halted", AW'(halted), AW'(m_halt));
    chk(tag, "exc_req", AW'(exc_req), AW'(e_req));
    if (e_req) begin
      chk(tag, "exc_vec", AW'(exc_vec), AW'(e_vec));
      chk(tag, "flt_addr", flt_addr, e_addr);
      chk(tag, "ret_pc", ret_pc, e_pc);
    end
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0; m_pv = 0; m_pwr = 0; m_pae = 0; m_halt = 0; e_req = 0;
    m_pa = 0; m_pp = 0; e_vec = 0; e_addr = 0; e_pc = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    chk("R10", "exc_req", AW'(exc_req), 0);
    chk("R10", "halted", AW'(halted), 0);
    // R1 data read fault fires at once
    fault_vld = 1; fault_kind = 1; fault_addr = 32'h1000; cur_pc = 32'h200; step("R1");
    // R2 prefetch held until use
    fault_vld = 1; fault_kind = 0; fault_addr = 32'h2000; step("R2");
    step("R2");
    pf_use = 1; step("R2");
    // R2 flush discards
    fault_vld = 1; fault_kind = 0; fault_addr = 32'h2100; step("R2");
    pf_flush = 1; step("R2");
    pf_use = 1; step("R2");
    // R3 released write: boundary, then operand access
    fault_vld = 1; fault_kind = 2; fault_addr = 32'h3000; step("R3");
    pf_use = 1; step("R3");
    boundary = 1; step("R3");
    fault_vld = 1; fault_kind = 2; fault_addr = 32'h3100; step("R3");
    opnd_acc = 1; step("R3");
    // R4 alignment
    acc_vld = 1; acc_kind = 1; acc_size = 0; acc_addr = 32'h501; step("R4");
    acc_vld = 1; acc_kind = 1; acc_size = 1; acc_addr = 32'h503; step("R4");
    acc_vld = 1; acc_kind = 1; acc_size = 2; acc_addr = 32'h505; step("R4");
    acc_vld = 1; acc_kind = 0; acc_size = 0; acc_addr = 32'h507; step("R4");
    pf_use = 1; step("R4");
    // R5 branches
    br_vld = 1; br_taken = 1; br_tgt = 32'h6001; step("R5");
    br_vld = 1; br_taken = 0; br_tgt = 32'h6003; step("R5");
    br_vld = 1; br_taken = 1; br_tgt = 32'h6004; step("R5");
    // R6 bus beats address in one cycle
    fault_vld = 1; fault_kind = 1; fault_addr = 32'h7000;
    acc_vld = 1; acc_kind = 1; acc_size = 1; acc_addr = 32'h7001; step("R6");
    // R9 single slot
    fault_vld = 1; fault_kind = 2; fault_addr = 32'h8000; step("R9");
    fault_vld = 1; fault_kind = 0; fault_addr = 32'h8100; step("R9");
    boundary = 1; step("R9");
    pf_use = 1; step("R9");
    fault_vld = 1; fault_kind = 0; fault_addr = 32'h8200; step("R9");
    do_reset();
    pf_use = 1; step("R9");
    // R7 / R8 double fault halt
    exc_phase = 1; fault_vld = 1; fault_kind = 1; fault_addr = 32'h9000; step("R7");
    fault_vld = 1; fault_kind = 1; step("R8");
    br_vld = 1; br_taken = 1; br_tgt = 32'h9001; step("R8");
    do_reset();
    chk("R8", "halted", AW'(halted), 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) do_reset();
      fault_vld = ($urandom % 100) < 12; fault_kind = 2'($urandom % 3);
      fault_addr = $urandom; cur_pc = $urandom & ~32'h1;
      acc_vld = ($urandom % 100) < 20; acc_kind = 2'($urandom % 3);
      acc_size = 2'($urandom % 3); acc_addr = $urandom;
      br_vld = ($urandom % 100) < 10; br_taken = $urandom % 2; br_tgt = $urandom;
      pf_use = ($urandom % 100) < 15; pf_flush = ($urandom % 100) < 8;
      boundary = ($urandom % 100) < 15; opnd_acc = ($urandom % 100) < 10;
      exc_phase = ($urandom % 1000) < 4;
      step("R1");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule